// File: doc/BRIEF.md
# Three-Phase Interleaved Peak-Current PWM

This block drives the gate-enable pulses of three step-down converter channels from a single shared switching timebase. One free-running counter sets the switching period, and each channel starts its own cycle at a fixed offset of one third of that period from its neighbour. The ripple drawn from the shared input capacitor is spread across the period instead of landing in one place.

At its cycle start an enabled channel turns its gate on. The pulse ends when that channel's current-trip input reports that switch current has reached the demand level, which gives cycle-by-cycle peak current limiting. If no trip arrives, a hard duty cap forces the gate off. A trip that lands before the minimum on-time point makes the channel drop its next pulse entirely, so it never issues a stream of runt pulses. The trip inputs come from external comparators, already retimed to the system clock. The analog sensing, slope compensation and error amplifier are outside this block.

Top module: `ipwm_top`

## Requirements
- R1: A synchronous active-high reset holds all three gates low and restarts the timebase. Channel 0's gate rises at the first clock edge after reset is released.
- R2: Channel k (k = 0, 1, 2) starts its cycle at the clock edge where the timebase count equals floor(k*PERIOD/3). Its gate is first seen high one clock after that count.
- R3: At its cycle start, a channel whose enable is high and which has no pending skip drives its gate high.
- R4: With no trip, a gate stays high for exactly floor(PERIOD*MAX_DUTY_PCT/100) clocks and is then forced low.
- R5: A trip seen while the gate is high ends the pulse at the next clock edge. The gate then stays low until the next cycle start, even if the trip is released. A trip on the same edge as the duty cap ends the pulse normally.
- R6: A trip that ends a pulse after fewer than floor(PERIOD*MIN_DUTY_PCT/100) high clocks makes the channel emit no pulse in its next cycle. The cycle after that is normal. A trip at exactly that many clocks causes no skip.
- R7: A trip input asserted while its channel's gate is low has no effect on the next pulse's width or on skipping.
- R8: A low enable forces that channel's gate low in the same clock cycle, including mid-pulse, and clears any pending skip. After enable returns, the gate stays low until the channel's next cycle start.
- R9: The timebase repeats every PERIOD clocks, so each channel starts a cycle once per PERIOD clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 3 | Per-channel enable, bit k for channel k |
| trip_i | input | 3 | Per-channel current-trip input, synchronous to clk_i, bit k for channel k |
| gate_o | output | 3 | Per-channel gate-drive pulse, bit k for channel k |

## Verification
Three pairs of events can fall in the same cycle: a trip and the duty-cap edge, a trip and a falling enable, and a trip and the channel's cycle start. The bench places a trip exactly on the cap edge and checks two things: the pulse width equals the cap, and no skip follows. It holds a trip high through the start edge while the gate is off and checks that the following pulse runs to full width. The constrained random phase raises trips and drops enables at random moments, including on cap and start edges. Every gate is compared each cycle against a cycle model that keeps its own on-time count and skip flag.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;
  localparam int unsigned NUM_PH = 3;

  // start offset of phase idx inside a period
  function automatic int unsigned phase_ofs(int unsigned period, int unsigned idx);
    return (idx * period) / NUM_PH;
  endfunction

  // percent of a period, rounded down, in clocks
  function automatic int unsigned duty_clocks(int unsigned period, int unsigned pct);
    return (period * pct) / 100;
  endfunction

  // position of the shared count relative to a phase's own start
  function automatic int unsigned local_phase(int unsigned cnt, int unsigned ofs,
                                              int unsigned period);
    return (cnt >= ofs) ? (cnt - ofs) : (cnt + period - ofs);
  endfunction
endpackage

// File: rtl/ipwm_timebase.sv
module ipwm_timebase #(
  parameter int unsigned PERIOD = 60,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (wrap_w) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST);
  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_w |=> (cnt_q == '0));
endmodule

// File: rtl/ipwm_channel.sv
module ipwm_channel #(
  parameter int unsigned PERIOD       = 60,
  parameter int unsigned IDX          = 0,
  parameter int unsigned MAX_DUTY_PCT = 90,
  parameter int unsigned MIN_DUTY_PCT = 5,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          trip_i,
  input  logic [CW-1:0] cnt_i,
  output logic          start_o,
  output logic          gate_o
);
  localparam int unsigned OFS    = ipwm_pkg::phase_ofs(PERIOD, IDX);
  localparam int unsigned MAX_ON = ipwm_pkg::duty_clocks(PERIOD, MAX_DUTY_PCT);
  localparam int unsigned MIN_ON = ipwm_pkg::duty_clocks(PERIOD, MIN_DUTY_PCT);
  localparam logic [CW-1:0] CAP_PH = CW'(MAX_ON);
  localparam logic [CW-1:0] MIN_PH = CW'(MIN_ON);

  logic [CW-1:0] ph_w;
  logic          start_w;   // cycle start edge of this channel
  logic          cap_w;     // duty cap reached
  logic          hit_w;     // trip accepted while gate high
  logic          runt_w;    // trip accepted before minimum on-time
  logic          gate_q, trip_q, skip_q;

  always_comb begin
    ph_w    = CW'(ipwm_pkg::local_phase(32'(cnt_i), OFS, PERIOD));
    start_w = (ph_w == '0);
    cap_w   = gate_q && (ph_w == CAP_PH);
    hit_w   = gate_o && trip_i;
    runt_w  = hit_w && (ph_w < MIN_PH);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gate_q <= 1'b0;
      trip_q <= 1'b0;
      skip_q <= 1'b0;
    end else if (!en_i) begin
      gate_q <= 1'b0;
      trip_q <= 1'b0;
      skip_q <= 1'b0;
    end else if (start_w) begin
      gate_q <= !skip_q;
      trip_q <= 1'b0;
      skip_q <= 1'b0;
    end else if (hit_w) begin
      gate_q <= 1'b0;
      trip_q <= 1'b1;
      if (runt_w) skip_q <= 1'b1;
    end else if (cap_w) begin
      gate_q <= 1'b0;
    end
  end

  assign gate_o  = gate_q & en_i;
  assign start_o = start_w;

  assert_start_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_w && en_i && !skip_q) |=> gate_q);
  assert_cap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    gate_q |-> (ph_w != '0 && ph_w <= CAP_PH));
  assert_trip_end_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_w |=> !gate_q);
  assert_trip_latch_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    trip_q |-> !gate_q);
  assert_skip_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_w && skip_q) |=> !gate_q);
  assert_ignore_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!gate_o && trip_i && !trip_q) |=> !trip_q);
  assert_disable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!gate_q && !skip_q));
endmodule

// File: rtl/ipwm_top.sv
module ipwm_top #(
  parameter int unsigned PERIOD       = 60,
  parameter int unsigned MAX_DUTY_PCT = 90,
  parameter int unsigned MIN_DUTY_PCT = 5
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] en_i,
  input  logic [2:0] trip_i,
  output logic [2:0] gate_o
);
  localparam int unsigned NPH = ipwm_pkg::NUM_PH;
  localparam int unsigned CW  = $clog2(PERIOD);

  logic [CW-1:0]  cnt_w;
  logic [NPH-1:0] start_w;

  ipwm_timebase #(.PERIOD(PERIOD)) u_timebase (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cnt_o (cnt_w)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ch
    ipwm_channel #(
      .PERIOD      (PERIOD),
      .IDX         (k),
      .MAX_DUTY_PCT(MAX_DUTY_PCT),
      .MIN_DUTY_PCT(MIN_DUTY_PCT)
    ) u_ch (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i[k]),
      .trip_i  (trip_i[k]),
      .cnt_i   (cnt_w),
      .start_o (start_w[k]),
      .gate_o  (gate_o[k])
    );
  end

  assert_phase_split_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(start_w));
  assert_ch0_origin_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    start_w[0] |-> (cnt_w == '0));
endmodule

// File: tb/ipwm_top_bench.sv
`timescale 1ns/1ps
module ipwm_top_bench;
  localparam int N    = 60;
  localparam int MAXP = 90;
  localparam int MINP = 5;

  function automatic int b_ofs(int k);  return (k * N) / 3;    endfunction
  function automatic int b_cap();       return (N * MAXP) / 100; endfunction
  function automatic int b_min();       return (N * MINP) / 100; endfunction

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] en, trip;
  logic [2:0] gate;

  ipwm_top #(.PERIOD(N), .MAX_DUTY_PCT(MAXP), .MIN_DUTY_PCT(MINP)) u_ipwm_top (
    .clk_i(clk), .rst_i(rst), .en_i(en), .trip_i(trip), .gate_o(gate)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int mcnt;
  bit mon[3], mskip[3], prev_g[3];
  int mlen[3], rise_cnt[3], last_width[3], run_len[3], last_rise[3], first_rise[3];
  int stepn;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle model: own on-time counter and pending-skip flag per channel
  task automatic model_edge(logic [2:0] e, logic [2:0] t);
    for (int k = 0; k < 3; k++) begin
      int ph;
      ph = (mcnt - b_ofs(k) + N) % N;
      if (!e[k]) begin
        mon[k] = 0; mlen[k] = 0; mskip[k] = 0;
      end else if (ph == 0) begin
        mon[k] = !mskip[k]; mlen[k] = mon[k] ? 1 : 0; mskip[k] = 0;
      end else if (mon[k]) begin
        if (t[k]) begin
          if (mlen[k] < b_min()) mskip[k] = 1;
          mon[k] = 0; mlen[k] = 0;
        end else if (mlen[k] == b_cap()) begin
          mon[k] = 0; mlen[k] = 0;
        end else mlen[k]++;
      end
    end
    mcnt = (mcnt + 1) % N;
  endtask

  task automatic step(logic [2:0] e, logic [2:0] t);
    en = e; trip = t;
    model_edge(e, t);
    @(negedge clk);
    stepn++;
    for (int k = 0; k < 3; k++) begin
      chk(gate[k] === (mon[k] & e[k]),
          $sformatf("R3 R4 R5 R6 R7 R8 per-cycle gate ch%0d step %0d", k, stepn),
          int'(gate[k]), int'(mon[k] & e[k]));
      if (gate[k]) begin
        if (!prev_g[k]) begin
          rise_cnt[k]++; run_len[k] = 1; last_rise[k] = stepn;
          if (first_rise[k] < 0) first_rise[k] = stepn;
        end else run_len[k]++;
      end else if (prev_g[k]) last_width[k] = run_len[k];
      prev_g[k] = gate[k];
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", stepn, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rc;
    rst = 1'b1; en = 3'b111; trip = 3'b000;
    repeat (4) @(negedge clk);
    chk(gate == 3'b000, "R1 gates low in reset", int'(gate), 0);
    rst = 1'b0;
    mcnt = 0; stepn = 0;
    for (int k = 0; k < 3; k++) begin
      mon[k] = 0; mskip[k] = 0; prev_g[k] = 0; mlen[k] = 0;
      rise_cnt[k] = 0; last_width[k] = 0; run_len[k] = 0;
      last_rise[k] = -1; first_rise[k] = -1;
    end

    // phase offsets, cap width, period
    repeat (2 * N) step(3'b111, 3'b000);
    chk(first_rise[0] == 1, "R1 ch0 first rise", first_rise[0], 1);
    for (int k = 1; k < 3; k++)
      chk(first_rise[k] == b_ofs(k) + 1, $sformatf("R2 ch%0d first rise", k),
          first_rise[k], b_ofs(k) + 1);
    chk(last_width[0] == b_cap(), "R4 untripped width", last_width[0], b_cap());
    chk(last_rise[0] == N + 1, "R9 period", last_rise[0], N + 1);

    // R5: trip after 10 clocks, released next cycle
    while (!(mon[0] && mlen[0] == 10)) step(3'b111, 3'b000);
    step(3'b111, 3'b001);
    repeat (5) step(3'b111, 3'b000);
    chk(gate[0] == 1'b0, "R5 latched off", int'(gate[0]), 0);
    chk(last_width[0] == 10, "R5 tripped width", last_width[0], 10);

    // R6: runt on ch1 skips one cycle
    while (!(mon[1] && mlen[1] == 1)) step(3'b111, 3'b000);
    step(3'b111, 3'b010);
    chk(last_width[1] == 1, "R6 runt width", last_width[1], 1);
    rc = rise_cnt[1];
    repeat (N) step(3'b111, 3'b000);
    chk(rise_cnt[1] == rc, "R6 skipped cycle", rise_cnt[1], rc);
    repeat (2 * N) step(3'b111, 3'b000);
    chk(last_width[1] == b_cap(), "R6 resumed width", last_width[1], b_cap());

    // R6 boundary: trip exactly at minimum on-time, no skip
    while (!(mon[2] && mlen[2] == b_min())) step(3'b111, 3'b000);
    step(3'b111, 3'b100);
    chk(last_width[2] == b_min(), "R6 boundary width", last_width[2], b_min());
    rc = rise_cnt[2];
    repeat (N) step(3'b111, 3'b000);
    chk(rise_cnt[2] == rc + 1, "R6 boundary no skip", rise_cnt[2], rc + 1);

    // R7: trip held only while ch0 gate is low
    rc = rise_cnt[0];
    repeat (2 * N) step(3'b111, {2'b00, !mon[0]});
    chk(rise_cnt[0] == rc + 2, "R7 no skip from idle trip", rise_cnt[0], rc + 2);
    chk(last_width[0] == b_cap(), "R7 full width", last_width[0], b_cap());

    // R8: enable drop mid-pulse, immediate
    while (!(mon[2] && mlen[2] == 20)) step(3'b111, 3'b000);
    en = 3'b011; #1;
    chk(gate[2] == 1'b0, "R8 immediate off", int'(gate[2]), 0);
    step(3'b011, 3'b000);
    step(3'b111, 3'b000);
    chk(gate[2] == 1'b0, "R8 stays low after re-enable", int'(gate[2]), 0);
    // R8: disable clears pending skip
    while (!(mon[2] && mlen[2] == 1)) step(3'b111, 3'b000);
    step(3'b111, 3'b100);
    step(3'b011, 3'b000);
    rc = rise_cnt[2];
    repeat (N) step(3'b111, 3'b000);
    chk(rise_cnt[2] == rc + 1, "R8 skip cleared", rise_cnt[2], rc + 1);

    // R4/R5 coincidence: trip on the cap edge
    while (!(mon[0] && mlen[0] == b_cap())) step(3'b111, 3'b000);
    step(3'b111, 3'b001);
    chk(last_width[0] == b_cap(), "R4 R5 trip on cap width", last_width[0], b_cap());
    rc = rise_cnt[0];
    repeat (N) step(3'b111, 3'b000);
    chk(rise_cnt[0] == rc + 1, "R5 no skip after cap trip", rise_cnt[0], rc + 1);

    // constrained random mix
    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] e, t;
      for (int k = 0; k < 3; k++) begin
        e[k] = ($urandom % 20) != 0;
        t[k] = mon[k] ? (($urandom % 12) == 0) : (($urandom % 4) == 0);
      end
      step(e, t);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule